// File: doc/BRIEF.md
# Carry Bypass Adder

A purely combinational binary adder for two N-bit operands and a carry-in. It produces the N-bit sum and a carry-out. The datapath is a chain of identical four-bit slices. Each slice forms a generate and a propagate term for every bit and ripples its carry internally from bit to bit. It also folds the per-bit terms into one slice-level generate/propagate pair. The slice's outgoing carry is taken from that pair and the slice's incoming carry, so a carry can jump over a slice without travelling through its four bit cells.

The per-bit propagate term is the OR of the two operand bits. A separate XOR forms the sum bit. Because of this, the slice-level skip contains no redundant logic. A wider adder is obtained only by raising the width parameter, which adds more copies of the same slice.

Top module: `bypass_adder`

## Requirements
- R1: For every input, `{co, sum}` equals the low WIDTH+1 bits of the unsigned sum `a + b + ci`.
- R2: WIDTH must be a multiple of 4. The adder consists of WIDTH/4 identical slices, and the same module gives a correct result at WIDTH=8 and at WIDTH=32.
- R3: With `a` all ones, `b` zero and `ci`=1, the carry crosses every slice: `sum` is zero and `co` is 1.
- R4: The carry leaving each slice through the skip path equals the carry rippled out of that slice's top bit.
- R5: A slice whose four bit positions all have at least one operand bit set passes its incoming carry on unchanged when it generates nothing itself. `a`=all ones, `b`=0 gives `co`=`ci`.
- R6: A slice whose four bit pairs are all zero blocks any carry. A slice that generates a carry delivers a carry-out of 1 whatever its carry-in. For example, `a`=0x000000FF, `b`=0x00000001, `ci`=0 gives sum 0x00000100 and `co`=0.
- R7: The outputs depend only on the present inputs, with no clock, storage or latency. All-zero inputs give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| ci | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + ci |
| co | output | 1 | Carry out of the top bit |

## Verification
The bench builds the adder twice. At WIDTH=8, two slices are small enough that all 2^17 combinations of both operands and the carry-in can be applied. This covers every interaction between the skip path and the internal ripple across one slice boundary. At WIDTH=32, eight slices give long skip chains. These are reached with directed patterns that propagate a carry across all slices, block it at a chosen slice, or generate it at the bottom, plus random vectors compared against a behavioural addition.

// File: rtl/bypass_adder_pkg.sv
package bypass_adder_pkg;

    localparam int SLICE_W = 4;

    typedef struct packed {
        logic gen;
        logic prop;
    } pg_t;

    // Per-bit terms: generate is AND, propagate is the inclusive OR.
    function automatic pg_t bit_pg(input logic a_bit, input logic b_bit);
        pg_t r;
        r.gen  = a_bit & b_bit;
        r.prop = a_bit | b_bit;
        return r;
    endfunction

    // Combine a more significant span (hi) with a less significant span (lo).
    function automatic pg_t pg_merge(input pg_t hi, input pg_t lo);
        pg_t r;
        r.gen  = hi.gen | (hi.prop & lo.gen);
        r.prop = hi.prop & lo.prop;
        return r;
    endfunction

    // Carry leaving a span given its pair and the carry entering it.
    function automatic logic pg_carry(input pg_t t, input logic c_in);
        return t.gen | (t.prop & c_in);
    endfunction

endpackage

// File: rtl/bypass_bit_cell.sv
module bypass_bit_cell
    import bypass_adder_pkg::*;
(
    input  logic a_bit,
    input  logic b_bit,
    input  logic c_in,
    output pg_t  pg,
    output logic s_bit,
    output logic c_out
);

    pg_t pg_w;

    always_comb begin
        pg_w  = bit_pg(a_bit, b_bit);
        s_bit = a_bit ^ b_bit ^ c_in;
        c_out = pg_carry(pg_w, c_in);
    end

    assign pg = pg_w;

endmodule

// File: rtl/bypass_group_pg.sv
module bypass_group_pg
    import bypass_adder_pkg::*;
#(
    parameter int BITS = SLICE_W
) (
    input  pg_t [BITS-1:0] bit_terms,
    output pg_t            grp
);

    pg_t [BITS-1:0] acc;

    assign acc[0] = bit_terms[0];

    genvar i;
    generate
        for (i = 1; i < BITS; i++) begin : g_fold
            assign acc[i] = pg_merge(bit_terms[i], acc[i-1]);
        end
    endgenerate

    assign grp = acc[BITS-1];

endmodule

// File: rtl/bypass_slice.sv
module bypass_slice
    import bypass_adder_pkg::*;
#(
    parameter int BITS = SLICE_W
) (
    input  logic [BITS-1:0] a_s,
    input  logic [BITS-1:0] b_s,
    input  logic            c_in,
    output logic [BITS-1:0] s_s,
    output logic            c_skip,
    output logic            c_ripple,
    output pg_t             grp
);

    pg_t [BITS-1:0]  terms;
    logic [BITS:0]   chain;

    assign chain[0] = c_in;

    genvar i;
    generate
        for (i = 0; i < BITS; i++) begin : g_bit
            bypass_bit_cell u_cell (
                .a_bit (a_s[i]),
                .b_bit (b_s[i]),
                .c_in  (chain[i]),
                .pg    (terms[i]),
                .s_bit (s_s[i]),
                .c_out (chain[i+1])
            );
        end
    endgenerate

    bypass_group_pg #(.BITS(BITS)) u_grp (
        .bit_terms (terms),
        .grp       (grp)
    );

    assign c_skip   = pg_carry(grp, c_in);
    assign c_ripple = chain[BITS];

endmodule

// File: rtl/bypass_adder.sv
module bypass_adder
    import bypass_adder_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             ci,
    output logic [WIDTH-1:0] sum,
    output logic             co
);

    localparam int NSEC = WIDTH / SLICE_W;

    generate
        if (WIDTH % SLICE_W != 0 || WIDTH < SLICE_W) begin : g_bad_width
            $error("bypass_adder: WIDTH must be a positive multiple of the slice width");
        end
    endgenerate

    logic [NSEC:0]   link;
    logic [NSEC-1:0] sec_ci;
    logic [NSEC-1:0] sec_co;
    logic [NSEC-1:0] sec_rip;
    logic [NSEC-1:0] sec_p;
    logic [NSEC-1:0] sec_g;

    assign link[0] = ci;

    genvar s;
    generate
        for (s = 0; s < NSEC; s++) begin : g_slice
            pg_t grp_w;

            bypass_slice #(.BITS(SLICE_W)) u_slice (
                .a_s      (a[s*SLICE_W +: SLICE_W]),
                .b_s      (b[s*SLICE_W +: SLICE_W]),
                .c_in     (link[s]),
                .s_s      (sum[s*SLICE_W +: SLICE_W]),
                .c_skip   (link[s+1]),
                .c_ripple (sec_rip[s]),
                .grp      (grp_w)
            );

            assign sec_ci[s] = link[s];
            assign sec_co[s] = link[s+1];
            assign sec_p[s]  = grp_w.prop;
            assign sec_g[s]  = grp_w.gen;
        end
    endgenerate

    assign co = link[NSEC];

endmodule

// File: rtl/bypass_adder_chk.sv
module bypass_adder_chk #(
    parameter int WIDTH = 32,
    parameter int NSEC  = 8
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             ci,
    input logic [WIDTH-1:0] sum,
    input logic             co,
    input logic [NSEC-1:0]  sec_ci,
    input logic [NSEC-1:0]  sec_co,
    input logic [NSEC-1:0]  sec_rip,
    input logic [NSEC-1:0]  sec_p,
    input logic [NSEC-1:0]  sec_g
);

    logic [WIDTH:0] ref_total;

    always_comb begin
        ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, ci};
        p_sum_matches_r1: assert ({co, sum} == ref_total)
            else $error("R1 sum mismatch");
        for (int s = 0; s < NSEC; s++) begin
            p_skip_equals_ripple_r4: assert (sec_co[s] == sec_rip[s])
                else $error("R4 skip and ripple carries differ");
            if (sec_p[s] && !sec_g[s]) begin
                p_pass_through_r5: assert (sec_co[s] == sec_ci[s])
                    else $error("R5 carry not passed");
            end
            if (sec_g[s]) begin
                p_generate_forces_r6: assert (sec_co[s])
                    else $error("R6 generated carry lost");
            end
            if (!sec_p[s] && !sec_g[s]) begin
                p_kill_blocks_r6: assert (!sec_co[s])
                    else $error("R6 carry not blocked");
            end
        end
    end

endmodule

bind bypass_adder bypass_adder_chk #(
    .WIDTH (WIDTH),
    .NSEC  (NSEC)
) u_chk (
    .a       (a),
    .b       (b),
    .ci      (ci),
    .sum     (sum),
    .co      (co),
    .sec_ci  (sec_ci),
    .sec_co  (sec_co),
    .sec_rip (sec_rip),
    .sec_p   (sec_p),
    .sec_g   (sec_g)
);

// File: tb/bypass_adder_tb.sv
module bypass_adder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W32 = 32;
    localparam int W8  = 8;
    localparam int WATCHDOG_CYCLES = 100000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W32-1:0] a32, b32, s32;
    logic           ci32, co32;
    logic [W8-1:0]  a8, b8, s8;
    logic           ci8, co8;

    bypass_adder #(.WIDTH(W32)) u_dut (
        .a(a32), .b(b32), .ci(ci32), .sum(s32), .co(co32)
    );

    bypass_adder #(.WIDTH(W8)) u_dut_n8 (
        .a(a8), .b(b8), .ci(ci8), .sum(s8), .co(co8)
    );

    task automatic check32(input logic [W32-1:0] ta, input logic [W32-1:0] tb_,
                           input logic tci, input string req);
        logic [W32:0] exp;
        @(negedge clk);
        a32 = ta; b32 = tb_; ci32 = tci;
        #1;
        exp = {1'b0, ta} + {1'b0, tb_} + {{W32{1'b0}}, tci};
        checks++;
        if ({co32, s32} !== exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h ci=%b got co=%b sum=%h expected co=%b sum=%h",
                     req, ta, tb_, tci, co32, s32, exp[W32], exp[W32-1:0]);
        end
    endtask

    task automatic check_fixed32(input logic [W32-1:0] ta, input logic [W32-1:0] tb_,
                                 input logic tci, input logic [W32-1:0] esum,
                                 input logic eco, input string req);
        @(negedge clk);
        a32 = ta; b32 = tb_; ci32 = tci;
        #1;
        checks++;
        if (s32 !== esum || co32 !== eco) begin
            errors++;
            $display("FAIL %s: got co=%b sum=%h expected co=%b sum=%h",
                     req, co32, s32, eco, esum);
        end
    endtask

    // R7: zero inputs give zero outputs with no clock involvement
    task automatic t_idle_state();
        check_fixed32('0, '0, 1'b0, '0, 1'b0, "R7 zero inputs");
        check_fixed32('0, '0, 1'b1, 32'h1, 1'b0, "R7 carry-in only");
    endtask

    // R1, R2: every vector of the two-slice adder
    task automatic t_exhaustive_n8();
        logic [W8:0] exp;
        for (int v = 0; v < (1 << (2*W8 + 1)); v++) begin
            {ci8, b8, a8} = v[2*W8:0];
            #1;
            exp = {1'b0, a8} + {1'b0, b8} + {{W8{1'b0}}, ci8};
            checks++;
            if ({co8, s8} !== exp) begin
                errors++;
                $display("FAIL R2 n8: a=%h b=%h ci=%b got %h expected %h",
                         a8, b8, ci8, {co8, s8}, exp);
            end
        end
    endtask

    // R3, R5: full propagation across every slice
    task automatic t_full_propagate();
        check_fixed32('1, '0, 1'b1, '0, 1'b1, "R3 carry through all slices");
        check_fixed32('1, '0, 1'b0, '1, 1'b0, "R5 propagate with ci=0");
        check_fixed32('0, '1, 1'b1, '0, 1'b1, "R5 propagate from b side");
        check_fixed32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, '0, 1'b1, "R5 mixed propagate");
    endtask

    // R4, R6: generate at the bottom, blocking in the middle
    task automatic t_generate_and_block();
        check_fixed32(32'h0000_0001, '1, 1'b0, '0, 1'b1, "R4 generated carry skips upward");
        check_fixed32('1, '1, 1'b1, '1, 1'b1, "R6 generate and propagate both set");
        check_fixed32(32'h0000_00FF, 32'h0000_0001, 1'b0, 32'h0000_0100, 1'b0, "R6 carry blocked");
        check_fixed32(32'h0F0F_FFFF, 32'h0000_0001, 1'b0, 32'h0F10_0000, 1'b0, "R6 carry stops at zero slice");
        check_fixed32(32'hF000_0000, 32'h1000_0000, 1'b1, 32'h0000_0001, 1'b1, "R6 top slice generates");
    endtask

    // R1: random operands at full width
    task automatic t_random32();
        for (int i = 0; i < 3000; i++) begin
            check32($urandom, $urandom, 1'($urandom), "R1 random");
        end
    endtask

    initial begin
        a32 = '0; b32 = '0; ci32 = 1'b0;
        a8 = '0; b8 = '0; ci8 = 1'b0;
        t_idle_state();
        t_full_propagate();
        t_generate_and_block();
        t_random32();
        t_exhaustive_n8();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG_CYCLES; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule